// File: doc/BRIEF.md
# Serial ADC Converter Emulator

This block stands in for an eight-input, 10-bit serial analog-to-digital converter. It lets a host-side command sequencer be tested without the real converter. It behaves as a serial-bus slave clocked from the system clock. The three host lines are chip select (active low), serial clock and serial data in. Each passes through a synchronizer, and the block detects their edges internally. The analog inputs are modelled as eight 10-bit digital words on one flat input port.

Each transfer carries a 4-bit command from the host, most significant bit first, sampled on rising serial-clock edges. During the same transfer the block returns the result of the previous conversion, most significant bit first, followed by zero padding. The returned data changes after falling serial-clock edges. When chip select rises after a complete command, a conversion starts. The end-of-conversion line goes low for a fixed number of system clocks, set by the current speed mode, and then returns high. On that rising edge the new result becomes the word returned by the next transfer. The command space selects one of eight inputs, three fixed self-test values, one of two speed modes, or power-down.

Top module: `adc_emu`

## Requirements
- R1: After reset, `eoc` is 1, `spi_miso_oe` is 0, and the first transfer returns a result of 0.
- R2: Command codes 0 to 7 convert input channel N, which occupies bits [10N+9:10N] of `ain_flat`. The next transfer returns that 10-bit value in its first 10 bits, MSB first, and the remaining FRAME_BITS-10 bits are 0.
- R3: Code 0xB converts to 10'h200, code 0xC to 10'h000 and code 0xD to 10'h3FF.
- R4: In fast mode (the reset default), a converting command drives `eoc` low for exactly FAST_CYCLES system clocks. This starts a few clocks after chip select rises, and `eoc` falls only in the cycle after a command is accepted.
- R5: Code 0xA selects slow mode and code 0x9 selects fast mode. In slow mode, conversions hold `eoc` low for exactly SLOW_CYCLES clocks. Both codes also start a conversion of the most recently selected source, using the newly chosen speed.
- R6: Code 0x8 (power-down) cancels any conversion in flight, keeps `eoc` high, starts no conversion and leaves the result unchanged. Any later valid command is executed normally.
- R7: Codes 0xE and 0xF have no effect: `eoc` stays high and the returned result is unchanged.
- R8: `spi_miso_oe` is 0 while the synchronized chip select is high and 1 while it is low. `spi_miso` reads 0 whenever `spi_miso_oe` is 0.
- R9: A transfer with fewer than 4 serial-clock rising edges is discarded: no conversion starts and no mode changes.
- R10: The selected input value is captured when the conversion starts. Changing `ain_flat` while `eoc` is low does not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select from host, active low |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_mosi | input | 1 | Command bits from host |
| ain_flat | input | 80 | Eight 10-bit modelled analog inputs, channel 0 in the low bits |
| spi_miso | output | 1 | Result bits to host |
| spi_miso_oe | output | 1 | Output enable for spi_miso (high while selected) |
| eoc | output | 1 | End of conversion, low while a conversion runs |

## Verification
The assertions assume the host never sends a converting command while `eoc` is low. A restart during a conversion would stretch the low pulse to a length that matches neither speed mode. They also assume each serial-clock phase lasts several system clocks, so that the synchronized edges stay in order. The stimulus keeps every serial-clock phase at four system clocks. After each chip-select rise it waits for `eoc` to return high before the next transfer, and power-down is issued only when the block is idle.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;

  localparam int CMD_W  = 4;
  localparam int NUM_CH = 8;

  localparam logic [CMD_W-1:0] CMD_PDOWN  = 4'h8;
  localparam logic [CMD_W-1:0] CMD_FAST   = 4'h9;
  localparam logic [CMD_W-1:0] CMD_SLOW   = 4'hA;
  localparam logic [CMD_W-1:0] CMD_T_MID  = 4'hB;
  localparam logic [CMD_W-1:0] CMD_T_LOW  = 4'hC;
  localparam logic [CMD_W-1:0] CMD_T_HIGH = 4'hD;

  typedef enum logic [2:0] {
    K_CHAN,
    K_TEST,
    K_PDOWN,
    K_FAST,
    K_SLOW,
    K_NONE
  } cmd_kind_e;

  function automatic cmd_kind_e classify(input logic [CMD_W-1:0] c);
    cmd_kind_e k;
    if (!c[CMD_W-1]) begin
      k = K_CHAN;
    end else begin
      case (c)
        CMD_PDOWN:                      k = K_PDOWN;
        CMD_FAST:                       k = K_FAST;
        CMD_SLOW:                       k = K_SLOW;
        CMD_T_MID, CMD_T_LOW, CMD_T_HIGH: k = K_TEST;
        default:                        k = K_NONE;
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/adc_emu_sync.sv
module adc_emu_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam int NST = (STAGES < 2) ? 2 : STAGES;

  logic [NST-1:0][W-1:0] stg_q;
  logic [NST-1:0][W-1:0] stg_n;

  always_comb begin
    stg_n = {stg_q[NST-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {NST{RST_VAL}};
    end else begin
      stg_q <= stg_n;
    end
  end

  assign q = stg_q[NST-1];

endmodule

// File: rtl/adc_emu_frame.sv
module adc_emu_frame
  import adc_emu_pkg::*;
#(
  parameter int RES_W      = 10,
  parameter int FRAME_BITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_cs_n,
  input  logic             s_sclk,
  input  logic             s_mosi,
  input  logic [RES_W-1:0] result,
  output logic             miso_bit,
  output logic             cmd_valid,
  output logic [CMD_W-1:0] cmd
);

  localparam int PAD   = FRAME_BITS - RES_W;
  localparam int BIT_W = $clog2(CMD_W + 1);
  localparam logic [BIT_W-1:0] FULL_CNT = BIT_W'(CMD_W);

  logic                  cs_d_q, sclk_d_q;
  logic [FRAME_BITS-1:0] out_q, out_n;
  logic [CMD_W-1:0]      in_q, in_n;
  logic [BIT_W-1:0]      nbits_q, nbits_n;

  logic cs_fall, cs_rise, sc_rise, sc_fall;

  assign cs_fall = cs_d_q & ~s_cs_n;
  assign cs_rise = ~cs_d_q & s_cs_n;
  assign sc_rise = ~sclk_d_q & s_sclk & ~s_cs_n;
  assign sc_fall = sclk_d_q & ~s_sclk & ~s_cs_n;

  always_comb begin
    out_n   = out_q;
    in_n    = in_q;
    nbits_n = nbits_q;
    if (cs_fall) begin
      out_n   = FRAME_BITS'(result) << PAD;
      in_n    = '0;
      nbits_n = '0;
    end else begin
      if (sc_fall) begin
        out_n = out_q << 1;
      end
      if (sc_rise && (nbits_q < FULL_CNT)) begin
        in_n    = {in_q[CMD_W-2:0], s_mosi};
        nbits_n = nbits_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d_q   <= 1'b1;
      sclk_d_q <= 1'b0;
      out_q    <= '0;
      in_q     <= '0;
      nbits_q  <= '0;
    end else begin
      cs_d_q   <= s_cs_n;
      sclk_d_q <= s_sclk;
      out_q    <= out_n;
      in_q     <= in_n;
      nbits_q  <= nbits_n;
    end
  end

  assign miso_bit  = out_q[FRAME_BITS-1];
  assign cmd_valid = cs_rise && (nbits_q == FULL_CNT);
  assign cmd       = in_q;

endmodule

// File: rtl/adc_emu_conv.sv
module adc_emu_conv
  import adc_emu_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int FAST_CYCLES = 24,
  parameter int SLOW_CYCLES = 96
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  input  logic [CMD_W-1:0]        cmd,
  input  logic [NUM_CH*RES_W-1:0] ain_flat,
  output logic                    eoc,
  output logic [RES_W-1:0]        result
);

  localparam int MAX_CYC = (FAST_CYCLES > SLOW_CYCLES) ? FAST_CYCLES : SLOW_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] FAST_LD = CNT_W'(FAST_CYCLES - 1);
  localparam logic [CNT_W-1:0] SLOW_LD = CNT_W'(SLOW_CYCLES - 1);
  localparam logic [RES_W-1:0] MID_VAL  = RES_W'(1) << (RES_W - 1);
  localparam logic [RES_W-1:0] HIGH_VAL = '1;

  logic [RES_W-1:0] ch_val [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign ch_val[g] = ain_flat[g*RES_W +: RES_W];
  end

  logic [CMD_W-1:0] src_q, src_n, src_sel;
  logic             slow_q, slow_n;
  logic             busy_q, busy_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [RES_W-1:0] pend_q, pend_n;
  logic [RES_W-1:0] res_q, res_n;
  logic [RES_W-1:0] src_val;
  cmd_kind_e        kind;
  logic             start;

  assign kind = classify(cmd);

  always_comb begin
    if (cmd_valid && (kind == K_CHAN || kind == K_TEST)) begin
      src_sel = cmd;
    end else begin
      src_sel = src_q;
    end
  end

  always_comb begin
    if (!src_sel[CMD_W-1]) begin
      src_val = ch_val[src_sel[2:0]];
    end else begin
      case (src_sel)
        CMD_T_MID: src_val = MID_VAL;
        CMD_T_LOW: src_val = '0;
        default:   src_val = HIGH_VAL;
      endcase
    end
  end

  always_comb begin
    src_n  = src_q;
    slow_n = slow_q;
    busy_n = busy_q;
    cnt_n  = cnt_q;
    pend_n = pend_q;
    res_n  = res_q;
    start  = 1'b0;

    if (busy_q) begin
      if (cnt_q == '0) begin
        busy_n = 1'b0;
        res_n  = pend_q;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end

    if (cmd_valid) begin
      case (kind)
        K_CHAN, K_TEST: begin
          src_n = cmd;
          start = 1'b1;
        end
        K_PDOWN: begin
          busy_n = 1'b0;
        end
        K_FAST: begin
          slow_n = 1'b0;
          start  = 1'b1;
        end
        K_SLOW: begin
          slow_n = 1'b1;
          start  = 1'b1;
        end
        default: ;
      endcase
    end

    if (start) begin
      busy_n = 1'b1;
      cnt_n  = slow_n ? SLOW_LD : FAST_LD;
      pend_n = src_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      slow_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      pend_q <= '0;
      res_q  <= '0;
    end else begin
      src_q  <= src_n;
      slow_q <= slow_n;
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      pend_q <= pend_n;
      res_q  <= res_n;
    end
  end

  assign eoc    = ~busy_q;
  assign result = res_q;

endmodule

// File: rtl/adc_emu.sv
module adc_emu
  import adc_emu_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int FRAME_BITS  = 16,
  parameter int FAST_CYCLES = 24,
  parameter int SLOW_CYCLES = 96,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    spi_cs_n,
  input  logic                    spi_sclk,
  input  logic                    spi_mosi,
  input  logic [NUM_CH*RES_W-1:0] ain_flat,
  output logic                    spi_miso,
  output logic                    spi_miso_oe,
  output logic                    eoc
);

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_pipe_q[1];

  logic [2:0] pins_raw, pins_s;

  assign pins_raw = {spi_cs_n, spi_sclk, spi_mosi};

  adc_emu_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (pins_raw),
    .q     (pins_s)
  );

  logic             miso_bit;
  logic             cmd_valid;
  logic [CMD_W-1:0] cmd;
  logic [RES_W-1:0] result;

  adc_emu_frame #(
    .RES_W      (RES_W),
    .FRAME_BITS (FRAME_BITS)
  ) u_frame (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .s_cs_n    (pins_s[2]),
    .s_sclk    (pins_s[1]),
    .s_mosi    (pins_s[0]),
    .result    (result),
    .miso_bit  (miso_bit),
    .cmd_valid (cmd_valid),
    .cmd       (cmd)
  );

  adc_emu_conv #(
    .RES_W       (RES_W),
    .FAST_CYCLES (FAST_CYCLES),
    .SLOW_CYCLES (SLOW_CYCLES)
  ) u_conv (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .ain_flat  (ain_flat),
    .eoc       (eoc),
    .result    (result)
  );

  assign spi_miso_oe = ~pins_s[2];
  assign spi_miso    = spi_miso_oe & miso_bit;

endmodule

// File: rtl/adc_emu_chk.sv
module adc_emu_chk #(
  parameter int FAST_CYCLES = 24,
  parameter int SLOW_CYCLES = 96
) (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_cs_n,
  input logic       spi_miso_oe,
  input logic       eoc,
  input logic       cmd_valid,
  input logic [3:0] cmd
);

  localparam int MAX_CYC = (FAST_CYCLES > SLOW_CYCLES) ? FAST_CYCLES : SLOW_CYCLES;
  localparam int CW      = $clog2(MAX_CYC + 2) + 1;
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (!eoc) begin
      if (low_cnt != CNT_MAX) begin
        low_cnt <= low_cnt + 1'b1;
      end
    end else begin
      low_cnt <= '0;
    end
  end

  AST_EOC_FALLS_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc) |-> $past(cmd_valid)); // R4

  AST_EOC_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(eoc) && !$past(cmd_valid)) |->
      (low_cnt == CW'(FAST_CYCLES) || low_cnt == CW'(SLOW_CYCLES))); // R5

  AST_PDOWN_EOC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == 4'h8) |=> eoc); // R6

  AST_IGNORED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd[3:1] == 3'b111 && eoc) |=> eoc); // R7

  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(spi_cs_n, 2) |-> !spi_miso_oe); // R8

  AST_OE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(spi_cs_n, 2) |-> spi_miso_oe); // R8

endmodule

bind adc_emu adc_emu_chk #(
  .FAST_CYCLES (FAST_CYCLES),
  .SLOW_CYCLES (SLOW_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .spi_cs_n    (spi_cs_n),
  .spi_miso_oe (spi_miso_oe),
  .eoc         (eoc),
  .cmd_valid   (cmd_valid),
  .cmd         (cmd)
);

// File: tb/adc_emu_tb_top.sv
module adc_emu_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int RES_W      = 10;
  localparam int FRAME      = 16;
  localparam int FAST       = 24;
  localparam int SLOW       = 96;
  localparam int HALF       = 4;
  localparam int NCH        = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic miso, oe, eoc;
  logic [RES_W-1:0]     ain_m [NCH];
  logic [NCH*RES_W-1:0] ain_flat;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar g = 0; g < NCH; g++) begin : g_ain
    assign ain_flat[g*RES_W +: RES_W] = ain_m[g];
  end

  adc_emu #(
    .RES_W       (RES_W),
    .FRAME_BITS  (FRAME),
    .FAST_CYCLES (FAST),
    .SLOW_CYCLES (SLOW),
    .SYNC_STAGES (2)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_cs_n    (cs_n),
    .spi_sclk    (sclk),
    .spi_mosi    (mosi),
    .ain_flat    (ain_flat),
    .spi_miso    (miso),
    .spi_miso_oe (oe),
    .eoc         (eoc)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [3:0]       m_src  = 4'h0;
  bit               m_slow = 1'b0;
  logic [RES_W-1:0] m_res  = '0;
  string            m_tag  = "R1";

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [RES_W-1:0] src_value(input logic [3:0] s);
    if (!s[3]) return ain_m[s[2:0]];
    case (s)
      4'hB:    return 10'h200;
      4'hC:    return 10'h000;
      default: return 10'h3FF;
    endcase
  endfunction

  task automatic xfer(input logic [3:0] c, input int nbits, output logic [FRAME-1:0] rd);
    rd = '0;
    tick(1);
    cs_n = 1'b0;
    sclk = 1'b0;
    tick(HALF);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      mosi = (i < 4) ? c[3-i] : 1'b0;
      tick(HALF);
      rd = {rd[FRAME-2:0], miso};
      if (i == 0) check("R8 oe while selected", int'(oe), 1);
      sclk = 1'b1;
      tick(HALF);
    end
    sclk = 1'b0;
    mosi = 1'b0;
    tick(HALF);
    cs_n = 1'b1;
  endtask

  task automatic do_cmd(input logic [3:0] c, input int nbits, input bit perturb);
    logic [FRAME-1:0] rd;
    logic [RES_W-1:0] pend;
    bit   conv, fell;
    int   lowc, exp_w;
    string tag;

    xfer(c, nbits, rd);
    if (nbits == FRAME) begin
      check({m_tag, " returned result"}, int'(rd[FRAME-1 -: RES_W]), int'(m_res));
      check("R2 zero padding", int'(rd[FRAME-RES_W-1:0]), 0);
    end

    conv = 1'b0;
    tag  = "R9";
    if (nbits >= 4) begin
      if (!c[3]) begin
        m_src = c; conv = 1'b1; tag = "R2";
      end else if (c == 4'hB || c == 4'hC || c == 4'hD) begin
        m_src = c; conv = 1'b1; tag = "R3";
      end else if (c == 4'h9) begin
        m_slow = 1'b0; conv = 1'b1; tag = "R5";
      end else if (c == 4'hA) begin
        m_slow = 1'b1; conv = 1'b1; tag = "R5";
      end else if (c == 4'h8) begin
        tag = "R6";
      end else begin
        tag = "R7";
      end
    end
    if (perturb) tag = "R10";
    pend  = src_value(m_src);
    exp_w = conv ? (m_slow ? SLOW : FAST) : 0;

    fell = 1'b0;
    lowc = 0;
    for (int k = 0; k < 40 && !fell; k++) begin
      tick(1);
      if (!eoc) fell = 1'b1;
    end
    if (fell) begin
      lowc = 1;
      if (perturb && !m_src[3]) ain_m[m_src[2:0]] = ain_m[m_src[2:0]] ^ 10'h155;
      while (lowc < 1000) begin
        tick(1);
        if (eoc) break;
        lowc++;
      end
    end
    if (conv && !m_slow)
      check({tag, " R4 eoc low cycles"}, lowc, exp_w);
    else
      check({tag, " eoc low cycles"}, lowc, exp_w);
    check("R8 oe idle", int'(oe), 0);
    check("R8 miso idle", int'(miso), 0);
    if (conv) begin
      m_res = pend;
      m_tag = tag;
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    bit idle_ok;
    for (int ch = 0; ch < NCH; ch++) ain_m[ch] = RES_W'(ch * 73 + 5);
    tick(3);
    rst_n = 1'b1;
    tick(5);
    check("R1 eoc after reset", int'(eoc), 1);
    check("R1 oe after reset", int'(oe), 0);
    check("R1 miso after reset", int'(miso), 0);

    do_cmd(4'h0, FRAME, 1'b0);

    for (int pass = 0; pass < 2; pass++) begin
      for (int ch = 0; ch < NCH; ch++) begin
        if (pass == 1) ain_m[ch] = ~RES_W'(ch * 73 + 5);
        do_cmd(4'(ch), FRAME, 1'b0);
      end
    end

    do_cmd(4'hB, FRAME, 1'b0);
    do_cmd(4'hC, FRAME, 1'b0);
    do_cmd(4'hD, FRAME, 1'b0);
    do_cmd(4'h3, FRAME, 1'b0);

    do_cmd(4'hA, FRAME, 1'b0);
    do_cmd(4'h6, FRAME, 1'b0);
    do_cmd(4'hD, FRAME, 1'b0);
    do_cmd(4'h9, FRAME, 1'b0);
    do_cmd(4'h1, FRAME, 1'b0);

    do_cmd(4'h8, FRAME, 1'b0);
    idle_ok = 1'b1;
    for (int k = 0; k < 100; k++) begin
      tick(1);
      if (!eoc) idle_ok = 1'b0;
    end
    check("R6 eoc held high in power-down", int'(idle_ok), 1);
    do_cmd(4'hE, FRAME, 1'b0);
    do_cmd(4'h2, FRAME, 1'b0);

    do_cmd(4'hF, FRAME, 1'b0);
    do_cmd(4'h5, 3, 1'b0);
    do_cmd(4'hA, 2, 1'b0);
    do_cmd(4'hE, FRAME, 1'b0);

    do_cmd(4'h4, FRAME, 1'b1);
    do_cmd(4'hE, FRAME, 1'b0);

    for (int c = 0; c < 16; c++) begin
      for (int ch = 0; ch < NCH; ch++) ain_m[ch] = RES_W'((c * 131 + ch * 29 + 17) % 1024);
      do_cmd(4'(c), FRAME, 1'b0);
    end
    for (int c = 15; c >= 0; c--) begin
      do_cmd(4'(c), FRAME, 1'b0);
    end
    do_cmd(4'hE, FRAME, 1'b0);

    report();
    $finish;
  end

endmodule